// File: doc/BRIEF.md
# Synchronized Gain Update Controller

This controller stands between a register write path and up to four programmable-gain amplifier channels. Its job is to make every gain change a timed event. Software stages new gain codes in shadow storage. Each staged code must pass a readback comparison before it is kept. A single apply request later moves every channel from its shadow code to its active code in the same clock cycle. That transfer happens only at the moment the converter's acquisition window closes.

Each transfer is marked by a one-cycle strobe. A busy signal follows it for a fixed settling guard. Writes are refused unless a short-lived unlock state is open. A communication error freezes all gains at their last confirmed values until software clears the fault. An overload request drives every channel to a safe code at the next boundary. After that, no further switch is allowed until a minimum dwell time has passed.

Top module: `gain_sync_ctrl`

## Requirements
- R1: After reset, every channel's active code equals RESET_CODE (1). The strobe, busy and both fault bits are 0.
- R2: A gain write is accepted only while the unlock state is open. The unlock state is opened by a one-cycle pulse on `unlock_i`. A write made without it has no effect on any later applied code.
- R3: The unlock state closes after one accepted write, or UNLOCK_TO (8) cycles after it was opened, whichever comes first. A write made after it closes is ignored.
- R4: An accepted write is stored in the shadow only if the next readback code matches it. On a mismatch the shadow keeps its old code and fault bit 1 (readback mismatch) is set.
- R5: Shadow codes never reach `gain_o` on their own. On an apply, all channels take their shadow codes in the same cycle. Channel n occupies bits [n*3 +: 3].
- R6: An apply happens only at a falling edge of the acquisition window, after two synchronizer stages. The codes change on the third rising clock edge after the window input falls. A request made while the window is high waits for that edge.
- R7: `apply_stb_o` is high for exactly the one cycle in which new codes first appear. `busy_o` is then high for GUARD (6) cycles.
- R8: `comm_err_i` sets fault bit 0. While that bit is set, no active code changes, pending apply and overload requests are dropped, and gain writes are refused.
- R9: An overload request sets all channels to SAFE_CODE (0) at the next boundary. No further switch occurs for DWELL (20) cycles after it. A request made during the dwell is carried to the first boundary after the dwell.
- R10: Fault bits are sticky. A bit is cleared only by `clr_valid_i` with a 1 in that bit of `clr_mask_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlock_i | input | 1 | Opens the write unlock state |
| wr_valid_i | input | 1 | Gain write strobe |
| wr_chan_i | input | 2 | Channel addressed by the write |
| wr_code_i | input | 3 | Gain code written |
| rb_valid_i | input | 1 | Readback data valid |
| rb_code_i | input | 3 | Code read back after the write |
| clr_valid_i | input | 1 | Fault clear strobe |
| clr_mask_i | input | 2 | Write-one-to-clear mask (bit0 comm, bit1 readback) |
| comm_err_i | input | 1 | Communication error indication |
| acq_win_i | input | 1 | Acquisition window, asynchronous |
| apply_req_i | input | 1 | Request to apply the shadow codes |
| ovl_req_i | input | 1 | Overload request for the safe range |
| gain_o | output | 12 | Active gain codes, 3 bits per channel |
| apply_stb_o | output | 1 | One-cycle apply strobe |
| busy_o | output | 1 | Settling guard in progress |
| fault_o | output | 2 | Sticky fault flags |

## Verification
Several properties are checked by assertions on every cycle:
- the active codes never move without the strobe;
- the strobe never falls inside the synchronized acquisition window;
- busy always follows the strobe;
- no strobe follows a cycle with the comm fault set;
- the unlock timer stays live while the unlock state is open;
- a fault bit clears only after a matching clear request.

Other behaviours can only be shown by the bench's scenarios. These are the deferral of a request across a long window, the refusal of writes that were never unlocked or came too late, the rejection of a mismatched readback, and the dropping of requests during a freeze. The bench also shows the dwell that holds back a second switch after an overload, each observed through the applied codes.

// File: rtl/gain_sync_pkg.sv
package gain_sync_pkg;
    localparam int FLT_COMM = 0;
    localparam int FLT_RB   = 1;
    localparam int NFLT     = 2;
endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.chain[STAGES-1];
    assign fall_o  = s_q.prev & ~s_q.chain[STAGES-1];
endmodule

// File: rtl/gs_faults.sv
module gs_faults
    import gain_sync_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLT-1:0] set_i,
    input  logic            clr_valid_i,
    input  logic [NFLT-1:0] clr_mask_i,
    output logic [NFLT-1:0] flt_o
);
    logic [NFLT-1:0] flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (clr_valid_i) flt_d = flt_d & ~clr_mask_i;
        flt_d = flt_d | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign flt_o = flt_q;

    generate
        for (genvar b = 0; b < NFLT; b++) begin : g_chk
            a_r10_sticky_until_cleared: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(flt_q[b]) |-> $past(clr_valid_i && clr_mask_i[b]));
        end
    endgenerate
endmodule

// File: rtl/gs_wrgate.sv
module gs_wrgate #(
    parameter int CW        = 3,
    parameter int CHW       = 2,
    parameter int UNLOCK_TO = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           block_i,
    input  logic           unlock_i,
    input  logic           wr_valid_i,
    input  logic [CHW-1:0] wr_chan_i,
    input  logic [CW-1:0]  wr_code_i,
    input  logic           rb_valid_i,
    input  logic [CW-1:0]  rb_code_i,
    output logic           commit_o,
    output logic [CHW-1:0] commit_chan_o,
    output logic [CW-1:0]  commit_code_o,
    output logic           rb_bad_o
);
    localparam int TW = $clog2(UNLOCK_TO + 1);

    typedef struct packed {
        logic           open;
        logic [TW-1:0]  timer;
        logic           pend;
        logic [CHW-1:0] chan;
        logic [CW-1:0]  code;
    } gate_t;

    gate_t g_d, g_q;
    logic  accept, rb_take;

    assign accept  = g_q.open & wr_valid_i & ~g_q.pend & ~block_i;
    assign rb_take = g_q.pend & rb_valid_i & ~block_i;

    always_comb begin
        g_d = g_q;
        if (g_q.open) begin
            g_d.timer = g_q.timer - 1'b1;
            if (g_q.timer == TW'(1)) g_d.open = 1'b0;
        end
        if (accept) begin
            g_d.open  = 1'b0;
            g_d.timer = '0;
            g_d.pend  = 1'b1;
            g_d.chan  = wr_chan_i;
            g_d.code  = wr_code_i;
        end
        if (unlock_i) begin
            g_d.open  = 1'b1;
            g_d.timer = TW'(UNLOCK_TO);
        end
        if (rb_take || block_i) g_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign commit_o      = rb_take & (rb_code_i == g_q.code);
    assign rb_bad_o      = rb_take & (rb_code_i != g_q.code);
    assign commit_chan_o = g_q.chan;
    assign commit_code_o = g_q.code;

    a_r3_unlock_timer_live: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.open |-> (g_q.timer != '0));
    a_r4_commit_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o || rb_bad_o) |-> $past(g_d.pend));
endmodule

// File: rtl/gain_sync_ctrl.sv
module gain_sync_ctrl
    import gain_sync_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int CW         = 3,
    parameter int GUARD      = 6,
    parameter int DWELL      = 20,
    parameter int UNLOCK_TO  = 8,
    parameter int RESET_CODE = 1,
    parameter int SAFE_CODE  = 0,
    parameter int CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlock_i,
    input  logic              wr_valid_i,
    input  logic [CHW-1:0]    wr_chan_i,
    input  logic [CW-1:0]     wr_code_i,
    input  logic              rb_valid_i,
    input  logic [CW-1:0]     rb_code_i,
    input  logic              clr_valid_i,
    input  logic [NFLT-1:0]   clr_mask_i,
    input  logic              comm_err_i,
    input  logic              acq_win_i,
    input  logic              apply_req_i,
    input  logic              ovl_req_i,
    output logic [NCH*CW-1:0] gain_o,
    output logic              apply_stb_o,
    output logic              busy_o,
    output logic [NFLT-1:0]   fault_o
);
    localparam int GW = $clog2(GUARD + 1);
    localparam int DW = $clog2(DWELL + 1);

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] shadow;
        logic [NCH-1:0][CW-1:0] active;
        logic                   apply_pend;
        logic                   ovl_pend;
        logic                   stb;
        logic [GW-1:0]          guard;
        logic [DW-1:0]          dwell;
    } ctl_t;

    ctl_t c_d, c_q;

    logic            acq_lvl, acq_fall, frozen;
    logic            commit, rb_bad;
    logic [CHW-1:0]  commit_chan;
    logic [CW-1:0]   commit_code;
    logic [NFLT-1:0] flt, flt_set;

    gs_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(acq_win_i),
        .level_o(acq_lvl), .fall_o(acq_fall)
    );

    gs_faults u_faults (
        .clk(clk), .rst_n(rst_n), .set_i(flt_set),
        .clr_valid_i(clr_valid_i), .clr_mask_i(clr_mask_i), .flt_o(flt)
    );

    assign frozen = flt[FLT_COMM] | comm_err_i;

    gs_wrgate #(.CW(CW), .CHW(CHW), .UNLOCK_TO(UNLOCK_TO)) u_wrgate (
        .clk(clk), .rst_n(rst_n), .block_i(frozen),
        .unlock_i(unlock_i), .wr_valid_i(wr_valid_i),
        .wr_chan_i(wr_chan_i), .wr_code_i(wr_code_i),
        .rb_valid_i(rb_valid_i), .rb_code_i(rb_code_i),
        .commit_o(commit), .commit_chan_o(commit_chan),
        .commit_code_o(commit_code), .rb_bad_o(rb_bad)
    );

    always_comb begin
        flt_set           = '0;
        flt_set[FLT_COMM] = comm_err_i;
        flt_set[FLT_RB]   = rb_bad;
    end

    always_comb begin
        c_d     = c_q;
        c_d.stb = 1'b0;
        if (c_q.guard != '0) c_d.guard = c_q.guard - 1'b1;
        if (c_q.dwell != '0) c_d.dwell = c_q.dwell - 1'b1;
        if (commit) c_d.shadow[commit_chan] = commit_code;
        if (apply_req_i) c_d.apply_pend = 1'b1;
        if (ovl_req_i)   c_d.ovl_pend   = 1'b1;
        if (frozen) begin
            c_d.apply_pend = 1'b0;
            c_d.ovl_pend   = 1'b0;
        end else if (acq_fall && c_q.guard == '0 && c_q.dwell == '0
                     && (c_d.apply_pend || c_d.ovl_pend)) begin
            if (c_d.ovl_pend) begin
                for (int c = 0; c < NCH; c++) c_d.active[c] = CW'(SAFE_CODE);
                c_d.ovl_pend = 1'b0;
                c_d.dwell    = DW'(DWELL);
            end else begin
                c_d.active     = c_d.shadow;
                c_d.apply_pend = 1'b0;
            end
            c_d.stb   = 1'b1;
            c_d.guard = GW'(GUARD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
            for (int c = 0; c < NCH; c++) begin
                c_q.shadow[c] <= CW'(RESET_CODE);
                c_q.active[c] <= CW'(RESET_CODE);
            end
        end else begin
            c_q <= c_d;
        end
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_out
            assign gain_o[c*CW +: CW] = c_q.active[c];
        end
    endgenerate

    assign apply_stb_o = c_q.stb;
    assign busy_o      = (c_q.guard != '0);
    assign fault_o     = flt;

    a_r5_change_only_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_o) |-> apply_stb_o);
    a_r6_strobe_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        apply_stb_o |-> !acq_lvl);
    a_r7_busy_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        apply_stb_o |-> busy_o);
    a_r8_no_switch_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o[FLT_COMM] |=> !apply_stb_o);
endmodule

// File: tb/gain_sync_ctrl_bench.sv
module gain_sync_ctrl_bench;
    localparam int NCH = 4, CW = 3, GUARD = 6, UNLOCK_TO = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic unlock_i = 0, wr_valid_i = 0, rb_valid_i = 0, clr_valid_i = 0;
    logic [1:0] wr_chan_i = 0;
    logic [2:0] wr_code_i = 0, rb_code_i = 0;
    logic [1:0] clr_mask_i = 0;
    logic comm_err_i = 0, acq_win_i = 0, apply_req_i = 0, ovl_req_i = 0;
    logic [NCH*CW-1:0] gain_o;
    logic apply_stb_o, busy_o;
    logic [1:0] fault_o;

    int n_chk = 0, n_bad = 0;
    logic [2:0] exp_g [NCH];

    always #5 clk = ~clk;

    gain_sync_ctrl u_gain_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .unlock_i(unlock_i), .wr_valid_i(wr_valid_i),
        .wr_chan_i(wr_chan_i), .wr_code_i(wr_code_i), .rb_valid_i(rb_valid_i),
        .rb_code_i(rb_code_i), .clr_valid_i(clr_valid_i), .clr_mask_i(clr_mask_i),
        .comm_err_i(comm_err_i), .acq_win_i(acq_win_i), .apply_req_i(apply_req_i),
        .ovl_req_i(ovl_req_i), .gain_o(gain_o), .apply_stb_o(apply_stb_o),
        .busy_o(busy_o), .fault_o(fault_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NCH*CW-1:0] packed_exp();
        logic [NCH*CW-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*CW +: CW] = exp_g[c];
        return v;
    endfunction

    task automatic pulse_unlock();
        unlock_i = 1; step(1); unlock_i = 0;
    endtask

    task automatic do_write(input logic [1:0] ch, input logic [2:0] code);
        wr_valid_i = 1; wr_chan_i = ch; wr_code_i = code; step(1); wr_valid_i = 0;
    endtask

    task automatic do_rb(input logic [2:0] code);
        rb_valid_i = 1; rb_code_i = code; step(1); rb_valid_i = 0;
    endtask

    task automatic req_apply();
        apply_req_i = 1; step(1); apply_req_i = 0;
    endtask

    // raise the window, then let it fall; returns at the negedge after the third rising edge
    task automatic window_cycle(input int high_len);
        acq_win_i = 1; step(high_len); acq_win_i = 0; step(3);
    endtask

    task automatic t_reset();
        chk(gain_o, packed_exp(), "R1 reset gains");
        chk(apply_stb_o, 0, "R1 reset strobe");
        chk(busy_o, 0, "R1 reset busy");
        chk(fault_o, 0, "R1 reset faults");
    endtask

    task automatic t_basic();
        pulse_unlock(); do_write(0, 5); do_rb(5);
        pulse_unlock(); do_write(2, 3); do_rb(3);
        step(3);
        chk(gain_o, packed_exp(), "R5 shadow hidden before apply");
        req_apply();
        acq_win_i = 1; step(4); acq_win_i = 0;
        step(2);
        chk(gain_o, packed_exp(), "R6 no change before third edge");
        step(1);
        exp_g[0] = 5; exp_g[2] = 3;
        chk(gain_o, packed_exp(), "R5 all channels together");
        chk(apply_stb_o, 1, "R7 strobe with change");
        chk(busy_o, 1, "R7 busy starts");
        step(1);
        chk(apply_stb_o, 0, "R7 strobe one cycle");
        step(GUARD - 2);
        chk(busy_o, 1, "R7 busy last guard cycle");
        step(1);
        chk(busy_o, 0, "R7 busy ends after guard");
    endtask

    task automatic t_defer();
        acq_win_i = 1;
        pulse_unlock(); do_write(1, 6); do_rb(6);
        req_apply();
        step(12);
        chk(gain_o, packed_exp(), "R6 deferred while window high");
        acq_win_i = 0; step(3);
        exp_g[1] = 6;
        chk(gain_o, packed_exp(), "R6 applied at window fall");
        step(GUARD + 2);
    endtask

    task automatic t_lock();
        do_write(3, 7); do_rb(7);
        pulse_unlock(); step(UNLOCK_TO + 2); do_write(3, 7); do_rb(7);
        req_apply(); window_cycle(3);
        chk(gain_o, packed_exp(), "R2 R3 writes without open unlock ignored");
        step(GUARD + 2);
        pulse_unlock(); do_write(3, 2); do_rb(2);
        do_write(0, 7); do_rb(7);
        req_apply(); window_cycle(3);
        exp_g[3] = 2;
        chk(gain_o, packed_exp(), "R3 one write per unlock");
        step(GUARD + 2);
    endtask

    task automatic t_readback();
        pulse_unlock(); do_write(0, 2); do_rb(4);
        chk(fault_o, 2'b10, "R4 mismatch flag");
        step(10);
        chk(fault_o, 2'b10, "R10 flag sticky");
        req_apply(); window_cycle(3);
        chk(gain_o, packed_exp(), "R4 rejected code not applied");
        step(GUARD + 2);
        clr_valid_i = 1; clr_mask_i = 2'b01; step(1); clr_valid_i = 0;
        chk(fault_o, 2'b10, "R10 other bit clear leaves flag");
        clr_valid_i = 1; clr_mask_i = 2'b10; step(1); clr_valid_i = 0;
        chk(fault_o, 2'b00, "R10 w1c clears flag");
    endtask

    task automatic t_comm();
        pulse_unlock(); do_write(1, 0); do_rb(0);
        req_apply();
        comm_err_i = 1; step(1); comm_err_i = 0;
        chk(fault_o, 2'b01, "R8 comm flag");
        window_cycle(3);
        chk(gain_o, packed_exp(), "R8 frozen at window fall");
        chk(apply_stb_o, 0, "R8 no strobe frozen");
        pulse_unlock(); do_write(2, 7); do_rb(7);
        clr_valid_i = 1; clr_mask_i = 2'b01; step(1); clr_valid_i = 0;
        chk(fault_o, 2'b00, "R10 comm flag cleared");
        window_cycle(3);
        chk(apply_stb_o, 0, "R8 pending request dropped");
        chk(gain_o, packed_exp(), "R8 no change after clear");
        req_apply(); window_cycle(3);
        exp_g[1] = 0;
        chk(gain_o, packed_exp(), "R8 frozen write refused, confirmed kept");
        step(GUARD + 2);
    endtask

    task automatic t_overload();
        ovl_req_i = 1; step(1); ovl_req_i = 0;
        window_cycle(3);
        chk(gain_o, 12'h000, "R9 safe code on all channels");
        chk(apply_stb_o, 1, "R9 strobe on overload switch");
        pulse_unlock(); do_write(3, 5); do_rb(5);
        req_apply(); window_cycle(2);
        chk(gain_o, 12'h000, "R9 dwell blocks switch");
        step(20);
        window_cycle(3);
        for (int c = 0; c < NCH; c++) exp_g[c] = 3'd0;
        exp_g[0] = 5; exp_g[2] = 3; exp_g[3] = 5; exp_g[1] = 0;
        chk(gain_o, packed_exp(), "R9 deferred apply after dwell");
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) exp_g[c] = 3'd1;
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_basic();
        t_defer();
        t_lock();
        t_readback();
        t_comm();
        t_overload();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule